// File: doc/BRIEF.md
# Binary32 Special-Case Resolver

This block sits in front of a single-precision arithmetic unit covering add, multiply, divide, fused multiply-add and square root. For each operation it looks at the opcode and the operands the operation uses. It settles at once the cases whose answer does not depend on finite arithmetic: a NaN operand, or an invalid mix of infinities and zeros. For those it produces the final result word with a "handled" flag. Otherwise it reports "not handled", and the finite datapath behind it computes the answer.

NaN selection always comes first. A signaling NaN beats a quiet one, and among NaNs of the same kind the operand nearest the front of the list (a, then b, then c) wins. The chosen NaN is returned quieted, with its sign and payload kept. Only when no used operand is a NaN does the block test the invalid combinations. Each invalid combination returns one fixed canonical quiet NaN, 0x7FC00000, and raises the invalid flag.

Requests enter through a valid/ready handshake and results leave through another, with one register stage between them. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty, or is being emptied in that same cycle (`out_ready` high). A result that is presented but not taken stays exactly as it is until `out_ready` rises.

Top module: `fpsc_resolver`

## Requirements
- R1: A request is accepted on a rising edge with `in_valid` and `in_ready` both high. `in_ready` equals (not `out_valid`) or `out_ready`. The result is presented with `out_valid` high from the next edge on. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_handled` and `out_invalid` do not change.
- R2: Opcode encoding: 0 add (a,b), 1 multiply (a,b), 2 divide (a,b), 3 fused multiply-add a*b+c (a,b,c), 4 square root (a). Operands an opcode does not list have no effect on its result. Codes 5 to 7 are never handled.
- R3: Fields of an operand: sign is bit 31, exponent bits 30:23, fraction bits 22:0. NaN means exponent all ones with fraction nonzero, and signaling NaN means a NaN with bit 22 clear. Among the used operands, the first signaling NaN in the order a, b, c is chosen. If there is none, the first NaN is chosen. The result is that operand with bit 22 set, with `out_handled` high.
- R4: When a NaN is returned, `out_invalid` is high exactly when the chosen operand was a signaling NaN.
- R5: Add with both operands infinite (exponent all ones, fraction zero) and of opposite sign returns 0x7FC00000 with handled and invalid high. Infinities of the same sign are not handled.
- R6: Multiply of an infinity by a zero (exponent and fraction zero, either sign), in either order, returns 0x7FC00000 with handled and invalid high.
- R7: Divide of an infinity by an infinity, with any signs, returns 0x7FC00000 with handled and invalid high.
- R8: Fused multiply-add returns 0x7FC00000 with handled and invalid high in two cases. The first is a product of an infinity and a zero. The second is a product that is infinite (an infinite factor and no zero factor) added to an infinite c of the other sign, where the product's sign is sign(a) xor sign(b).
- R9: Square root of a negative, nonzero, non-NaN operand (including -inf and negative subnormals) returns 0x7FC00000 with handled and invalid high. Square root of -0 is not handled.
- R10: A NaN among the used operands takes precedence over every invalid combination: the NaN result of R3 and R4 is returned instead of the canonical NaN.
- R11: When no case above applies, `out_handled` and `out_invalid` are low and `out_result` is zero.
- R12: During and right after reset (`rst_n` low), `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_op | input | 3 | Operation code (see R2) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_c | input | 32 | Third operand (fused multiply-add addend) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Special result word, or zero when not handled |
| out_handled | output | 1 | Result is final; the finite datapath is skipped |
| out_invalid | output | 1 | Invalid-operation indication |

## Verification
Every result is due on the first rising edge after the edge that accepts its request. It then stays in place through any number of stalled cycles until the edge where `out_ready` is high. The bench keeps its own model of the output stage and changes it only at the edges where the handshake rules say a request is taken or a result is drained. It changes all inputs and compares every output at the falling edge, half a period away from any active edge. The sweep covers every opcode with every combination of zero, infinity, quiet NaN, signaling NaN, finite and negative subnormal values, both signs, in all three operand slots.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_MUL  = 3'd1,
    OP_DIV  = 3'd2,
    OP_FMA  = 3'd3,
    OP_SQRT = 3'd4
  } fpsc_op_e;

  // Class summary of one operand, independent of the format widths.
  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_inf;
    logic is_nan;
    logic is_snan;
  } fpsc_cls_t;

endpackage

// File: rtl/fpsc_classify.sv
module fpsc_classify
  import fpsc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output fpsc_cls_t             cls
);
  logic [EXP_W-1:0]  expf;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones;
  logic              frac_nz;

  assign expf     = word[EXP_W+FRAC_W-1:FRAC_W];
  assign frac     = word[FRAC_W-1:0];
  assign exp_ones = &expf;
  assign frac_nz  = |frac;

  assign cls.sign    = word[EXP_W+FRAC_W];
  assign cls.is_zero = ~(|expf) & ~frac_nz;
  assign cls.is_inf  = exp_ones & ~frac_nz;
  assign cls.is_nan  = exp_ones & frac_nz;
  assign cls.is_snan = exp_ones & frac_nz & ~frac[FRAC_W-1];
endmodule

// File: rtl/fpsc_nan_pick.sv
module fpsc_nan_pick
  import fpsc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int N_OPS  = 3,
  parameter int QBIT   = 22
) (
  input  logic [WORD_W-1:0] words [N_OPS],
  input  fpsc_cls_t         cls   [N_OPS],
  input  logic [N_OPS-1:0]  used,
  output logic              found,
  output logic              was_snan,
  output logic [WORD_W-1:0] nan_word
);
  localparam int IDX_W = (N_OPS > 1) ? $clog2(N_OPS) : 1;
  localparam logic [WORD_W-1:0] QMASK = WORD_W'(1) << QBIT;

  logic [IDX_W-1:0] idx;

  // Two backward scans: the last write is the lowest index, and the
  // signaling scan overrides the quiet one.
  always_comb begin
    found    = 1'b0;
    was_snan = 1'b0;
    idx      = '0;
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (used[i] && cls[i].is_nan) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (used[i] && cls[i].is_snan) begin
        was_snan = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  assign nan_word = words[idx] | QMASK;

  always_comb begin
    if (was_snan) begin
      assert_snan_implies_found_R4: assert (found)
        else $error("signaling pick without NaN found");
    end
  end
endmodule

// File: rtl/fpsc_invalid_check.sv
module fpsc_invalid_check
  import fpsc_pkg::*;
(
  input  logic [2:0] op,
  input  fpsc_cls_t  ca,
  input  fpsc_cls_t  cb,
  input  fpsc_cls_t  cc,
  output logic       bad
);
  logic inf_times_zero;
  logic prod_inf;
  logic prod_sign;

  assign inf_times_zero = (ca.is_inf & cb.is_zero) | (ca.is_zero & cb.is_inf);
  assign prod_inf       = (ca.is_inf | cb.is_inf) & ~ca.is_zero & ~cb.is_zero;
  assign prod_sign      = ca.sign ^ cb.sign;

  always_comb begin
    bad = 1'b0;
    unique case (op)
      OP_ADD:  bad = ca.is_inf & cb.is_inf & (ca.sign ^ cb.sign);
      OP_MUL:  bad = inf_times_zero;
      OP_DIV:  bad = ca.is_inf & cb.is_inf;
      OP_FMA:  bad = inf_times_zero |
                     (prod_inf & cc.is_inf & (prod_sign ^ cc.sign));
      OP_SQRT: bad = ca.sign & ~ca.is_zero & ~ca.is_nan;
      default: bad = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpsc_resolver.sv
module fpsc_resolver
  import fpsc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [2:0]              in_op,
  input  logic [EXP_W+FRAC_W:0]   in_a,
  input  logic [EXP_W+FRAC_W:0]   in_b,
  input  logic [EXP_W+FRAC_W:0]   in_c,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [EXP_W+FRAC_W:0]   out_result,
  output logic                    out_handled,
  output logic                    out_invalid
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int N_OPS  = 3;
  localparam logic [WORD_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [WORD_W-1:0] opw [N_OPS];
  fpsc_cls_t         opc [N_OPS];
  logic [N_OPS-1:0]  used;
  logic              nan_found, nan_snan, bad_combo;
  logic [WORD_W-1:0] nan_word;
  logic [WORD_W-1:0] res_d;
  logic              hit_d, inv_d;

  assign opw[0] = in_a;
  assign opw[1] = in_b;
  assign opw[2] = in_c;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fpsc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (opw[g]),
      .cls  (opc[g])
    );
  end

  // Operands taking part in each operation.
  always_comb begin
    unique case (in_op)
      OP_ADD, OP_MUL, OP_DIV: used = 3'b011;
      OP_FMA:                 used = 3'b111;
      OP_SQRT:                used = 3'b001;
      default:                used = 3'b000;
    endcase
  end

  fpsc_nan_pick #(.WORD_W(WORD_W), .N_OPS(N_OPS), .QBIT(FRAC_W-1)) u_pick (
    .words    (opw),
    .cls      (opc),
    .used     (used),
    .found    (nan_found),
    .was_snan (nan_snan),
    .nan_word (nan_word)
  );

  fpsc_invalid_check u_inv (
    .op  (in_op),
    .ca  (opc[0]),
    .cb  (opc[1]),
    .cc  (opc[2]),
    .bad (bad_combo)
  );

  // NaN selection first; invalid combinations only when no NaN is found.
  always_comb begin
    if (nan_found) begin
      res_d = nan_word;
      hit_d = 1'b1;
      inv_d = nan_snan;
    end else if (bad_combo) begin
      res_d = CANON_NAN;
      hit_d = 1'b1;
      inv_d = 1'b1;
    end else begin
      res_d = '0;
      hit_d = 1'b0;
      inv_d = 1'b0;
    end
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_handled <= 1'b0;
      out_invalid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= res_d;
        out_handled <= hit_d;
        out_invalid <= inv_d;
      end
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted request did not appear");

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_handled) && $stable(out_invalid)))
    else $error("stalled result changed");

  assert_unknown_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op > 3'd4) |=> !out_handled)
    else $error("reserved opcode handled");

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_handled) |->
      ((&out_result[WORD_W-2:FRAC_W]) && out_result[FRAC_W-1]))
    else $error("handled result is not a quiet NaN");

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_handled) |-> (out_result == '0 && !out_invalid))
    else $error("unhandled result not zero");
endmodule

// File: tb/fpsc_resolver_tb.sv
`timescale 1ns/1ps
module fpsc_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  in_op;
  logic [31:0] in_a, in_b, in_c, out_result;
  logic        out_handled, out_invalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the output stage
  bit          m_valid = 0;
  logic [31:0] m_res;
  bit          m_h, m_i;
  string       m_tag;
  // expectation for the request currently on the inputs
  logic [31:0] e_res;
  bit          e_h, e_i;
  string       e_tag;

  always #2.5 clk = ~clk;

  fpsc_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_handled(out_handled), .out_invalid(out_invalid)
  );

  function automatic bit f_nan(logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  function automatic bit f_snan(logic [31:0] w);
    return f_nan(w) && !w[22];
  endfunction
  function automatic bit f_inf(logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] == 0);
  endfunction
  function automatic bit f_zero(logic [31:0] w);
    return w[30:0] == 0;
  endfunction

  // operand classes: 0 +0, 1 -0, 2 +inf, 3 -inf, 4 qNaN, 5 sNaN,
  // 6 +finite, 7 -finite, 8 -subnormal
  function automatic logic [31:0] make_val(int k, logic [31:0] s);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7F80_0000;
      3: return 32'hFF80_0000;
      4: return 32'h7FC0_0000 | (s & 32'h803F_FFFF);
      5: return 32'h7F80_0001 | (s & 32'h803F_FFFF);
      6: return 32'h3F80_0000 + (s & 32'h0000_FFFF);
      7: return 32'hBF80_0000 + (s & 32'h0000_FFFF);
      default: return 32'h8000_0001 | (s & 32'h0000_00FF);
    endcase
  endfunction

  function automatic void model(input int op, input logic [31:0] a,
                                input logic [31:0] b, input logic [31:0] c,
                                output logic [31:0] r, output bit h,
                                output bit iv, output string tag);
    logic [31:0] v [3];
    int n, sel;
    bit combo, pinf, psign, unused_nan;
    v[0] = a; v[1] = b; v[2] = c;
    n = (op <= 2) ? 2 : (op == 3) ? 3 : (op == 4) ? 1 : 0;
    sel = -1;
    for (int i = 0; i < n; i++) if (sel < 0 && f_snan(v[i])) sel = i;
    for (int i = 0; i < n; i++) if (sel < 0 && f_nan(v[i])) sel = i;
    unused_nan = 0;
    for (int i = n; i < 3; i++) if (f_nan(v[i])) unused_nan = 1;
    combo = 0;
    pinf  = (f_inf(a) || f_inf(b)) && !f_zero(a) && !f_zero(b);
    psign = a[31] ^ b[31];
    case (op)
      0: combo = f_inf(a) && f_inf(b) && (a[31] != b[31]);
      1: combo = (f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b));
      2: combo = f_inf(a) && f_inf(b);
      3: combo = (f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b)) ||
                 (pinf && f_inf(c) && (psign != c[31]));
      4: combo = a[31] && !f_zero(a) && !f_nan(a);
      default: combo = 0;
    endcase
    if (op > 4) begin
      r = 0; h = 0; iv = 0; tag = "R2";
    end else if (sel >= 0) begin
      r = v[sel] | 32'h0040_0000; h = 1; iv = f_snan(v[sel]);
      tag = combo ? "R10" : (iv ? "R4" : "R3");
    end else if (combo) begin
      r = 32'h7FC0_0000; h = 1; iv = 1;
      case (op)
        0: tag = "R5";
        1: tag = "R6";
        2: tag = "R7";
        3: tag = "R8";
        default: tag = "R9";
      endcase
    end else begin
      r = 0; h = 0; iv = 0;
      tag = unused_nan ? "R2" : "R11";
    end
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: inputs already set at this falling edge; compares at the next.
  task automatic tick(output bit acc);
    out_ready = (($urandom % 4) != 0);
    #1;
    check("R1", "in_ready", {31'd0, in_ready}, {31'd0, (!m_valid || out_ready)});
    acc = in_valid && (!m_valid || out_ready);
    if (m_valid && out_ready) m_valid = 0;
    if (acc) begin
      m_valid = 1; m_res = e_res; m_h = e_h; m_i = e_i; m_tag = e_tag;
    end
    @(negedge clk);
    check("R1", "out_valid", {31'd0, out_valid}, {31'd0, m_valid});
    if (m_valid) begin
      check(m_tag, "out_result",  out_result, m_res);
      check(m_tag, "out_handled", {31'd0, out_handled}, {31'd0, m_h});
      check(m_tag, "out_invalid", {31'd0, out_invalid}, {31'd0, m_i});
    end
  endtask

  initial begin
    bit acc;
    int txn;
    rst_n = 0; in_valid = 0; out_ready = 0;
    in_op = 0; in_a = 0; in_b = 0; in_c = 0;
    repeat (3) @(negedge clk);
    check("R12", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R12", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    txn = 0;
    for (int op = 0; op < 8; op++) begin
      for (int ka = 0; ka < 9; ka++) begin
        for (int kb = 0; kb < 9; kb++) begin
          for (int kc = 0; kc < 9; kc++) begin
            logic [31:0] s;
            s = 32'(txn) * 32'h9E37_79B9;
            txn++;
            if (($urandom % 8) == 0) begin
              in_valid = 0;
              in_a = $urandom; in_b = $urandom; in_c = $urandom;
              tick(acc);
            end
            in_op = 3'(op);
            in_a = make_val(ka, s);
            in_b = make_val(kb, s ^ 32'h1357_9BDF);
            in_c = make_val(kc, s ^ 32'h2468_ACE0);
            model(op, in_a, in_b, in_c, e_res, e_h, e_i, e_tag);
            in_valid = 1;
            acc = 0;
            while (!acc) tick(acc);
          end
        end
      end
    end
    in_valid = 0;
    while (m_valid) tick(acc);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule